// File: doc/BRIEF.md
# Dual-Path PWM Tick Generator

This block turns the bus clock into six per-channel tick enables for a pulse-width modulation unit. Two separate divider paths, A and B, each start with a power-of-two prescaler. Each prescaled tick stream then drives an 8-bit programmable scaler. The scaler emits one tick every 2·N prescaled ticks, and a scale value of zero stands for 256.

Each channel has a select bit. The bit picks either the plain prescaled tick of its path or the scaled tick of that path. Channels 0, 1, 4 and 5 belong to path A, and channels 2 and 3 belong to path B.

Every output is a one-bus-cycle enable, registered once, that a channel counter uses as its count enable. No derived clock nets are made. A write strobe for a scale register restarts that scaler, so a new division takes effect from a known point.

Top module: `pwm_clock_gen`

## Requirements
- R1: While `rst_n` is low, all six `tick` outputs are cleared at each clock edge.
- R2: The path A prescale code is read from `presc_ctrl[2:0]` and the path B code from `presc_ctrl[6:4]`. Bits 7 and 3 of `presc_ctrl` have no effect on any output.
- R3: A prescale code n (0 to 7) gives an unscaled tick once every 2^n bus cycles. Code 0 gives a tick on every bus cycle.
- R4: A scaled tick repeats every 2·N·2^n bus cycles, where N (1 to 255) is the scale value of the path and n is the prescale code of the path.
- R5: A scale value of 0 divides the prescaled ticks by 512.
- R6: Bit k of `clk_sel` controls channel k: 0 selects the unscaled tick and 1 selects the scaled tick. Channels 0, 1, 4 and 5 take path A, and channels 2 and 3 take path B. Bits 7 and 6 of `clk_sel` are ignored.
- R7: A scaled tick never lasts more than one bus cycle. Two scaled ticks are never adjacent.
- R8: A scale write restarts the scaler. With prescale code 0, the first scaled tick after the write appears on `tick` exactly 2·N bus cycles after the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_ctrl | input | 8 | Prescale codes: path B in [6:4], path A in [2:0] |
| scale_a | input | 8 | Path A scale value N (0 means 256) |
| scale_a_wr | input | 1 | One-cycle strobe: restart path A scaler |
| scale_b | input | 8 | Path B scale value N (0 means 256) |
| scale_b_wr | input | 1 | One-cycle strobe: restart path B scaler |
| clk_sel | input | 8 | Per-channel select, bit k for channel k (1 = scaled) |
| tick | output | 6 | Registered per-channel tick enables |

## Verification
The hardest case to reach from the ports is the restart of a scaler in the middle of its count. The write must land while the scaler holds a value that is neither its reload value nor zero, otherwise a missing restart looks the same as a correct one. The stimulus first waits for a scaled tick on the output, then lets a fixed number of cycles pass, and then writes the same scale value again. The following tick must come a full 2·N cycles after the write, and not at the end of the count that was already running. Period checks skip the first tick after each reconfiguration, so the phase of the free-running prescaler does not disturb the measured interval.

// File: rtl/pwm_clkgen_pkg.sv
// Package: shared sizing and channel-to-path mapping for the PWM tick generator.
// Assumes six channels and two divider paths; all widths derive from here.
package pwm_clkgen_pkg;

    localparam int NUM_CH     = 6;
    localparam int NUM_PATH   = 2;
    localparam int CODE_W     = 3;
    localparam int SCALE_W    = 8;
    localparam int REG_W      = 8;
    localparam int A_CODE_LSB = 0;
    localparam int B_CODE_LSB = 4;

    // Prescaler counter needs 2^CODE_W - 1 bits to divide by up to 2^(2^CODE_W - 1).
    localparam int PRE_CNT_W  = (1 << CODE_W) - 1;
    // Scaler counts up to 2*2^SCALE_W - 1.
    localparam int SC_CNT_W   = SCALE_W + 1;

    typedef enum logic {
        PATH_A = 1'b0,
        PATH_B = 1'b1
    } path_e;

    // Bit k set: channel k belongs to path B.
    localparam logic [NUM_CH-1:0] CH_ON_PATH_B = 6'b001100;

endpackage

// File: rtl/pwm_clk_prescaler.sv
// Module: power-of-two prescaler. A free-running counter emits a one-cycle
// enable whenever its low `code` bits are all ones, so the enable rate is
// clk / 2^code. Assumes code may change at any time; only the phase of the
// next enable is affected.
module pwm_clk_prescaler #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              en_o
);

    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] low_mask;

    // Free-running divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_cnt <= '0;
        end else begin
            free_cnt <= free_cnt + 1'b1;
        end
    end

    // Mask of the low code bits; enable when they are all ones.
    always_comb begin
        low_mask = ~({CNT_W{1'b1}} << code);
        en_o     = ((free_cnt & low_mask) == low_mask);
    end

endmodule

// File: rtl/pwm_clk_scaler.sv
// Module: programmable even divider on a tick stream. It counts input enables
// down from 2*N-1 and emits one enable when the count is zero and an input
// enable arrives, then reloads. N = 0 stands for 256. A restart strobe loads
// the count from the current scale value and suppresses an output that cycle.
// Assumes en_i is a single-cycle enable in the clk domain.
module pwm_clk_scaler #(
    parameter int SCALE_W = 8,
    parameter int CNT_W   = SCALE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [SCALE_W-1:0] scale,
    input  logic               restart,
    output logic               en_o
);

    logic [CNT_W-1:0] down_cnt;
    logic [CNT_W-1:0] reload_val;
    logic             cnt_zero;

    // Reload value 2*N-1, with N = 0 taken as 2^SCALE_W.
    always_comb begin
        if (scale == '0) begin
            reload_val = {CNT_W{1'b1}};
        end else begin
            reload_val = {scale, 1'b0} - CNT_W'(1);
        end
        cnt_zero = (down_cnt == '0);
    end

    // Down-counter: restart, reload on expiry, or step on each input enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_cnt <= '0;
        end else if (restart) begin
            down_cnt <= reload_val;
        end else if (en_i) begin
            if (cnt_zero) begin
                down_cnt <= reload_val;
            end else begin
                down_cnt <= down_cnt - 1'b1;
            end
        end
    end

    // Output enable on expiry, not during a restart.
    always_comb begin
        en_o = en_i && cnt_zero && !restart;
    end

endmodule

// File: rtl/pwm_clk_chan_sel.sv
// Module: per-channel source selection. Each channel takes the unscaled or the
// scaled enable of its fixed path, chosen by its select bit. Assumes the
// path map is constant and given as a parameter.
module pwm_clk_chan_sel
    import pwm_clkgen_pkg::*;
#(
    parameter int                 CH_N   = NUM_CH,
    parameter int                 PATH_N = NUM_PATH,
    parameter logic [CH_N-1:0]    ON_B   = CH_ON_PATH_B
) (
    input  logic [CH_N-1:0]   sel,
    input  logic [PATH_N-1:0] pre_en,
    input  logic [PATH_N-1:0] scl_en,
    output logic [CH_N-1:0]   tick_d
);

    for (genvar k = 0; k < CH_N; k++) begin : g_ch
        localparam path_e CH_PATH = ON_B[k] ? PATH_B : PATH_A;
        // Pick scaled or unscaled enable of this channel's path.
        always_comb begin
            tick_d[k] = sel[k] ? scl_en[CH_PATH] : pre_en[CH_PATH];
        end
    end

endmodule

// File: rtl/pwm_clock_gen.sv
// Module: top of the dual-path PWM tick generator. Two prescalers feed two
// scalers; six channels choose a source each; outputs are registered so each
// tick is a clean one-cycle enable. Assumes scale strobes are one cycle wide
// and that register values are held stable by the surrounding logic.
module pwm_clock_gen
    import pwm_clkgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   presc_ctrl,
    input  logic [SCALE_W-1:0] scale_a,
    input  logic               scale_a_wr,
    input  logic [SCALE_W-1:0] scale_b,
    input  logic               scale_b_wr,
    input  logic [REG_W-1:0]   clk_sel,
    output logic [NUM_CH-1:0]  tick
);

    localparam int CODE_LSB [NUM_PATH] = '{A_CODE_LSB, B_CODE_LSB};

    logic [NUM_PATH-1:0]              pre_en;
    logic [NUM_PATH-1:0]              scl_en;
    logic [NUM_PATH-1:0][SCALE_W-1:0] scale_val;
    logic [NUM_PATH-1:0]              scale_wr;
    logic [NUM_CH-1:0]                tick_d;

    // Gather per-path scale inputs into arrays.
    always_comb begin
        scale_val[PATH_A] = scale_a;
        scale_val[PATH_B] = scale_b;
        scale_wr[PATH_A]  = scale_a_wr;
        scale_wr[PATH_B]  = scale_b_wr;
    end

    for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
        pwm_clk_prescaler #(
            .CODE_W (CODE_W),
            .CNT_W  (PRE_CNT_W)
        ) i_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .code   (presc_ctrl[CODE_LSB[p] +: CODE_W]),
            .en_o   (pre_en[p])
        );

        pwm_clk_scaler #(
            .SCALE_W (SCALE_W),
            .CNT_W   (SC_CNT_W)
        ) i_scl (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (pre_en[p]),
            .scale   (scale_val[p]),
            .restart (scale_wr[p]),
            .en_o    (scl_en[p])
        );
    end

    pwm_clk_chan_sel #(
        .CH_N   (NUM_CH),
        .PATH_N (NUM_PATH),
        .ON_B   (CH_ON_PATH_B)
    ) i_sel (
        .sel    (clk_sel[NUM_CH-1:0]),
        .pre_en (pre_en),
        .scl_en (scl_en),
        .tick_d (tick_d)
    );

    // Output register: one-cycle ticks, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
        end else begin
            tick <= tick_d;
        end
    end

endmodule

// File: rtl/pwm_clock_gen_chk.sv
// Checker: temporal properties of the tick generator, bound to the top.
module pwm_clock_gen_chk
    import pwm_clkgen_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [REG_W-1:0]   presc_ctrl,
    input logic [REG_W-1:0]   clk_sel,
    input logic [NUM_CH-1:0]  tick
);

    logic seen;

    // Marks that one clock edge out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (tick == '0));

    assert_code0_path_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(presc_ctrl[2:0]) == 3'd0 && !$past(clk_sel[0])) |-> tick[0]);

    assert_code0_path_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(presc_ctrl[6:4]) == 3'd0 && !$past(clk_sel[2])) |-> tick[2]);

    assert_group_a01_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(clk_sel[0]) == $past(clk_sel[1])) |-> (tick[0] == tick[1]));

    assert_group_a04_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(clk_sel[0]) == $past(clk_sel[4])) |-> (tick[0] == tick[4]));

    assert_group_a45_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(clk_sel[4]) == $past(clk_sel[5])) |-> (tick[4] == tick[5]));

    assert_group_b23_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(clk_sel[2]) == $past(clk_sel[3])) |-> (tick[2] == tick[3]));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_single
        assert_scaled_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && tick[k] && $past(clk_sel[k]) && clk_sel[k]) |=> !tick[k]);
    end

endmodule

bind pwm_clock_gen pwm_clock_gen_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .presc_ctrl (presc_ctrl),
    .clk_sel    (clk_sel),
    .tick       (tick)
);

// File: tb/test_pwm_clock_gen.sv
module test_pwm_clock_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] presc_ctrl = '0;
    logic [7:0] scale_a = '0;
    logic       scale_a_wr = 1'b0;
    logic [7:0] scale_b = '0;
    logic       scale_b_wr = 1'b0;
    logic [7:0] clk_sel = '0;
    logic [5:0] tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_clock_gen i_pwm_clock_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .presc_ctrl (presc_ctrl),
        .scale_a    (scale_a),
        .scale_a_wr (scale_a_wr),
        .scale_b    (scale_b),
        .scale_b_wr (scale_b_wr),
        .clk_sel    (clk_sel),
        .tick       (tick)
    );

    typedef struct packed {
        logic [7:0]      presc;
        logic [7:0]      sa;
        logic [7:0]      sb;
        logic [7:0]      sel;
        logic [5:0][9:0] per;   // expected period per channel, index = channel
        logic [7:0]      req;   // requirement number shown in messages
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        // R3: code 0 both paths, unscaled -> every cycle
        '{8'h00, 8'd3, 8'd5, 8'h00, {10'd1, 10'd1, 10'd1, 10'd1, 10'd1, 10'd1}, 8'd3},
        // R3/R2: A code 1 (/2), B code 2 (/4)
        '{8'h21, 8'd3, 8'd5, 8'h00, {10'd2, 10'd2, 10'd4, 10'd4, 10'd2, 10'd2}, 8'd2},
        // R4: SA = 2*2*3 = 12, SB = 4*2*5 = 40
        '{8'h21, 8'd3, 8'd5, 8'h3F, {10'd12, 10'd12, 10'd40, 10'd40, 10'd12, 10'd12}, 8'd4},
        // R5: sa = 0 -> 512 on ch1; sb = 1 -> 2 on ch3
        '{8'h00, 8'd0, 8'd1, 8'h0A, {10'd1, 10'd1, 10'd2, 10'd1, 10'd512, 10'd1}, 8'd5},
        // R6: mixed select, B code 7
        '{8'h70, 8'd1, 8'd2, 8'h35, {10'd2, 10'd2, 10'd128, 10'd512, 10'd1, 10'd2}, 8'd6},
        // R5: A code 7 unscaled = 128; SB with sb = 0 = 512
        '{8'h07, 8'd2, 8'd0, 8'h0C, {10'd128, 10'd128, 10'd512, 10'd512, 10'd128, 10'd128}, 8'd5},
        // R2/R6: ignored bits presc[7], presc[3], sel[7:6] -> all every cycle
        '{8'h88, 8'd4, 8'd4, 8'hC0, {10'd1, 10'd1, 10'd1, 10'd1, 10'd1, 10'd1}, 8'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [7:0] pc, input logic [7:0] sa,
                             input logic [7:0] sb, input logic [7:0] sel);
        @(negedge clk);
        presc_ctrl = pc;
        scale_a    = sa;
        scale_b    = sb;
        clk_sel    = sel;
        scale_a_wr = 1'b1;
        scale_b_wr = 1'b1;
        @(negedge clk);
        scale_a_wr = 1'b0;
        scale_b_wr = 1'b0;
    endtask

    // Interval between the 2nd and 3rd ticks seen; -1 on timeout.
    task automatic measure(input int ch, output int iv);
        int seen = 0;
        int cyc  = 0;
        int last = 0;
        iv = -1;
        while (seen < 3 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (tick[ch]) begin
                if (seen == 2) iv = cyc - last;
                last = cyc;
                seen++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int iv;
        int n;
        bit found;

        // R1: outputs cleared while in reset (code 0 would otherwise tick)
        repeat (3) @(negedge clk);
        check(tick == 6'b0, "R1 reset", int'(tick), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk: period on every channel
        for (int v = 0; v < NV; v++) begin
            apply_cfg(VECS[v].presc, VECS[v].sa, VECS[v].sb, VECS[v].sel);
            for (int ch = 0; ch < 6; ch++) begin
                measure(ch, iv);
                check(iv == int'(VECS[v].per[ch]),
                      $sformatf("R%0d vec%0d ch%0d", VECS[v].req, v, ch),
                      iv, int'(VECS[v].per[ch]));
            end
        end

        // R7: scaled tick is one cycle wide (sa = 1, code 0 -> high, low)
        apply_cfg(8'h00, 8'd1, 8'd1, 8'h01);
        found = 1'b0;
        for (int i = 0; i < 10 && !found; i++) begin
            @(negedge clk);
            if (tick[0]) found = 1'b1;
        end
        @(negedge clk);
        check(found && !tick[0], "R7 pulse width", int'(tick[0]), 0);

        // R8: mid-count restart, N = 10 -> next tick 20 cycles after write edge
        apply_cfg(8'h00, 8'd10, 8'd1, 8'h01);
        found = 1'b0;
        for (int i = 0; i < 100 && !found; i++) begin
            @(negedge clk);
            if (tick[0]) found = 1'b1;
        end
        repeat (7) @(negedge clk);
        scale_a_wr = 1'b1;
        @(posedge clk);
        n = 0;
        found = 1'b0;
        while (!found && n < 100) begin
            @(negedge clk);
            scale_a_wr = 1'b0;
            if (tick[0]) found = 1'b1;
            else begin
                @(posedge clk);
                n++;
            end
        end
        check(n == 20, "R8 restart latency", n, 20);

        // R1: reset asserted mid-run clears outputs
        apply_cfg(8'h00, 8'd1, 8'd1, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(tick == 6'b0, "R1 reset mid-run", int'(tick), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule